// File: doc/BRIEF.md
# Reset Cause Status Logger

This block keeps four status flags that together record which event last reset or woke the processor. The flags are power-on seen (`porFlag`), brown-out seen (`borFlag`), watchdog not expired (`toFlag`) and not powered down (`pdFlag`). Each incoming event strobe applies its own rule to every flag: set it, clear it, or leave it as it was. Firmware can later decode the flag pattern to tell power-on, brown-out, watchdog reset, watchdog wake-up, pin reset while running, pin reset while asleep and interrupt wake-up apart.

The block also produces the program counter value the core must load after the event. Resets restart at address zero. Wake-ups resume at the instruction after the one that was executing. An interrupt wake-up with interrupts globally enabled goes to the interrupt vector instead.

Hardware can only ever clear the power-on and brown-out flags. Software sets them again through a small write port, so that a later clear shows up as a new event. When several strobes arrive in the same cycle, one fixed priority picks a single winner. All outputs are registered and change on the clock edge that samples the strobe.

Top module: `resetCauseLogger`

## Requirements
- R1: While `rstN` is low, and after it is released with no event pending, the outputs are `porFlag`=0, `borFlag`=0, `toFlag`=1, `pdFlag`=1 and `resumePc`=0.
- R2: A power-on strobe clears `porFlag`, sets `toFlag` and `pdFlag`, and loads `resumePc` with 0 on the next edge. `borFlag` keeps its old register value, which is treated as unknown.
- R3: A brown-out strobe clears `borFlag`, sets `toFlag` and `pdFlag`, loads `resumePc` with 0, and leaves `porFlag` unchanged.
- R4: A watchdog reset clears `toFlag`, sets `pdFlag` and loads 0. A watchdog wake-up clears both `toFlag` and `pdFlag` and loads `pcIn`+1, truncated to `PC_W` bits so that the all-ones value wraps to 0.
- R5: A pin reset while running loads 0 and leaves `toFlag` and `pdFlag` unchanged. A pin reset while sleeping loads 0, sets `toFlag` and clears `pdFlag`.
- R6: An interrupt wake-up sets `toFlag` and clears `pdFlag`. It loads `VEC_ADDR` (default 0004h) when `gie` is 1, and `pcIn`+1 (wrapping) when `gie` is 0.
- R7: A sleep-entry strobe sets `toFlag`, clears `pdFlag` and leaves `resumePc` unchanged.
- R8: When several strobes are high in one cycle, only the highest-priority one takes effect. The order from highest to lowest is: power-on, brown-out, pin reset while sleeping, pin reset while running, watchdog reset, watchdog wake-up, interrupt wake-up, sleep entry.
- R9: With `swWrEn` high, `porFlag` and `borFlag` take `swPor` and `swBor` on the next edge, unless the winning event clears that flag in the same cycle, in which case the flag reads 0. Only power-on clears `porFlag` and only brown-out clears `borFlag`; no other event changes either flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the logger registers |
| evPowerOn | input | 1 | Power-on event strobe |
| evBrownOut | input | 1 | Brown-out event strobe |
| evPinRun | input | 1 | Pin reset while running |
| evPinSleep | input | 1 | Pin reset while sleeping |
| evWdtReset | input | 1 | Watchdog time-out while running |
| evWdtWake | input | 1 | Watchdog time-out while sleeping |
| evIntWake | input | 1 | Interrupt wake-up from sleep |
| evSleep | input | 1 | Sleep-entry strobe |
| gie | input | 1 | Global interrupt enable level |
| pcIn | input | PC_W | Current program counter |
| swWrEn | input | 1 | Software write strobe for `porFlag` and `borFlag` |
| swPor | input | 1 | Value written to `porFlag` |
| swBor | input | 1 | Value written to `borFlag` |
| porFlag | output | 1 | Power-on status flag |
| borFlag | output | 1 | Brown-out status flag |
| toFlag | output | 1 | Watchdog time-out flag |
| pdFlag | output | 1 | Power-down flag |
| resumePc | output | PC_W | Program counter value to load after the event |

## Verification
The bench first sweeps all 256 combinations of the eight event strobes. Each combination is tried with both `gie` levels, with and without a software write, and with several `pcIn` values, including all-ones. These cases separate the priority winner (R8) from lower-priority strobes that must have no effect, and the vector from the PC+1 path. A second pass applies each event on its own, with flags written to 1 beforehand. This shows which flags each event leaves unchanged, and whether a clear beats a simultaneous software set. The bench ignores `borFlag` after a power-on until software or a brown-out gives it a defined value.

// File: rtl/rcl_pkg.sv
package rcl_pkg;
  typedef enum logic [1:0] {PC_KEEP, PC_ZERO, PC_NEXT, PC_VEC} pcSel_e;

  // strobes from the event decoder to the flag datapath
  typedef struct packed {
    logic   porClr;
    logic   borClr;
    logic   toWr;
    logic   toVal;
    logic   pdWr;
    logic   pdVal;
    pcSel_e pcSel;
  } flagCtrl_t;

  localparam int NUM_EV = 8;
  // bit index equals priority rank, 0 highest
  localparam int EV_POWER     = 0;
  localparam int EV_BROWN     = 1;
  localparam int EV_PIN_SLEEP = 2;
  localparam int EV_PIN_RUN   = 3;
  localparam int EV_WDT_RST   = 4;
  localparam int EV_WDT_WAKE  = 5;
  localparam int EV_INT_WAKE  = 6;
  localparam int EV_SLEEP     = 7;
endpackage

// File: rtl/rclEventCtrl.sv
module rclEventCtrl
  import rcl_pkg::*;
(
  input  logic [NUM_EV-1:0] evVec,
  input  logic              gie,
  output flagCtrl_t         ctrl
);
  logic [NUM_EV-1:0] winner;

  // isolate the lowest-index (highest-priority) strobe
  always_comb begin
    winner = '0;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (evVec[i]) winner = NUM_EV'(1) << i;
    end
  end

  always_comb begin
    ctrl = '0;
    ctrl.pcSel = PC_KEEP;
    unique case (1'b1)
      winner[EV_POWER]: begin
        ctrl.porClr = 1'b1;
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b1;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b1;
        ctrl.pcSel = PC_ZERO;
      end
      winner[EV_BROWN]: begin
        ctrl.borClr = 1'b1;
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b1;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b1;
        ctrl.pcSel = PC_ZERO;
      end
      winner[EV_PIN_SLEEP]: begin
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b1;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b0;
        ctrl.pcSel = PC_ZERO;
      end
      winner[EV_PIN_RUN]: begin
        ctrl.pcSel = PC_ZERO;
      end
      winner[EV_WDT_RST]: begin
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b0;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b1;
        ctrl.pcSel = PC_ZERO;
      end
      winner[EV_WDT_WAKE]: begin
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b0;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b0;
        ctrl.pcSel = PC_NEXT;
      end
      winner[EV_INT_WAKE]: begin
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b1;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b0;
        ctrl.pcSel = gie ? PC_VEC : PC_NEXT;
      end
      winner[EV_SLEEP]: begin
        ctrl.toWr = 1'b1; ctrl.toVal = 1'b1;
        ctrl.pdWr = 1'b1; ctrl.pdVal = 1'b0;
      end
      default: ;
    endcase
  end

  // R8
  always_comb begin
    single_winner_chk: assert ($onehot0(winner) && ((winner & ~evVec) == '0));
  end
endmodule

// File: rtl/rclFlagPath.sv
module rclFlagPath
  import rcl_pkg::*;
#(
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VEC_ADDR = PC_W'(4)
) (
  input  logic            clk,
  input  logic            rstN,
  input  flagCtrl_t       ctrl,
  input  logic            swWrEn,
  input  logic            swPor,
  input  logic            swBor,
  input  logic [PC_W-1:0] pcIn,
  output logic            porFlag,
  output logic            borFlag,
  output logic            toFlag,
  output logic            pdFlag,
  output logic [PC_W-1:0] resumePc
);
  logic [PC_W-1:0] pcNext;

  always_comb begin
    unique case (ctrl.pcSel)
      PC_ZERO: pcNext = '0;
      PC_NEXT: pcNext = pcIn + PC_W'(1);
      PC_VEC:  pcNext = VEC_ADDR;
      default: pcNext = resumePc;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      porFlag  <= 1'b0;
      borFlag  <= 1'b0;
      toFlag   <= 1'b1;
      pdFlag   <= 1'b1;
      resumePc <= '0;
    end else begin
      if (ctrl.porClr)  porFlag <= 1'b0;
      else if (swWrEn)  porFlag <= swPor;
      if (ctrl.borClr)  borFlag <= 1'b0;
      else if (swWrEn)  borFlag <= swBor;
      if (ctrl.toWr)    toFlag <= ctrl.toVal;
      if (ctrl.pdWr)    pdFlag <= ctrl.pdVal;
      resumePc <= pcNext;
    end
  end

  // R9
  por_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.porClr |=> !porFlag);
  // R9
  bor_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.borClr |=> !borFlag);
  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.pcSel == PC_KEEP) |=> $stable(resumePc));
endmodule

// File: rtl/resetCauseLogger.sv
module resetCauseLogger
  import rcl_pkg::*;
#(
  parameter int PC_W = 13,
  parameter logic [PC_W-1:0] VEC_ADDR = PC_W'(4)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evPowerOn,
  input  logic            evBrownOut,
  input  logic            evPinRun,
  input  logic            evPinSleep,
  input  logic            evWdtReset,
  input  logic            evWdtWake,
  input  logic            evIntWake,
  input  logic            evSleep,
  input  logic            gie,
  input  logic [PC_W-1:0] pcIn,
  input  logic            swWrEn,
  input  logic            swPor,
  input  logic            swBor,
  output logic            porFlag,
  output logic            borFlag,
  output logic            toFlag,
  output logic            pdFlag,
  output logic [PC_W-1:0] resumePc
);
  logic [NUM_EV-1:0] evVec;
  flagCtrl_t         ctrl;

  always_comb begin
    evVec = '0;
    evVec[EV_POWER]     = evPowerOn;
    evVec[EV_BROWN]     = evBrownOut;
    evVec[EV_PIN_SLEEP] = evPinSleep;
    evVec[EV_PIN_RUN]   = evPinRun;
    evVec[EV_WDT_RST]   = evWdtReset;
    evVec[EV_WDT_WAKE]  = evWdtWake;
    evVec[EV_INT_WAKE]  = evIntWake;
    evVec[EV_SLEEP]     = evSleep;
  end

  rclEventCtrl ctrl_i (.evVec(evVec), .gie(gie), .ctrl(ctrl));

  rclFlagPath #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) path_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .swWrEn(swWrEn), .swPor(swPor), .swBor(swBor), .pcIn(pcIn),
    .porFlag(porFlag), .borFlag(borFlag), .toFlag(toFlag), .pdFlag(pdFlag),
    .resumePc(resumePc)
  );

  logic noneAboveInt;
  assign noneAboveInt = !(evPowerOn | evBrownOut | evPinSleep | evPinRun |
                          evWdtReset | evWdtWake);

  // R2
  power_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    evPowerOn |=> (!porFlag && toFlag && pdFlag && resumePc == '0));
  // R3
  brown_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evBrownOut && !evPowerOn) |=>
      (!borFlag && toFlag && pdFlag && resumePc == '0 && porFlag == $past(swWrEn ? swPor : porFlag)));
  // R6
  int_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evIntWake && gie && noneAboveInt) |=> (resumePc == VEC_ADDR && toFlag && !pdFlag));
  // R9
  por_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(porFlag) |-> $past(swWrEn && swPor));
endmodule

// File: tb/resetCauseLogger_tb.sv
module resetCauseLogger_tb_top;
  localparam int PC_W = 13;
  localparam logic [PC_W-1:0] VEC = 13'h004;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] ev = '0;
  logic gie = 1'b0, swWrEn = 1'b0, swPor = 1'b0, swBor = 1'b0;
  logic [PC_W-1:0] pcIn = '0;
  logic porFlag, borFlag, toFlag, pdFlag;
  logic [PC_W-1:0] resumePc;

  always #5 clk = ~clk;

  resetCauseLogger #(.PC_W(PC_W), .VEC_ADDR(VEC)) dut_i (
    .clk(clk), .rstN(rstN),
    .evPowerOn(ev[0]), .evBrownOut(ev[1]), .evPinSleep(ev[2]), .evPinRun(ev[3]),
    .evWdtReset(ev[4]), .evWdtWake(ev[5]), .evIntWake(ev[6]), .evSleep(ev[7]),
    .gie(gie), .pcIn(pcIn), .swWrEn(swWrEn), .swPor(swPor), .swBor(swBor),
    .porFlag(porFlag), .borFlag(borFlag), .toFlag(toFlag), .pdFlag(pdFlag),
    .resumePc(resumePc)
  );

  int nVec = 0, nBad = 0;
  logic ePor = 1'b0, eBor = 1'b0, eTo = 1'b1, ePd = 1'b1, borKnown = 1'b1;
  logic [PC_W-1:0] ePc = '0;
  string curReq = "R1";

  task automatic compare();
    nVec++;
    if (porFlag !== ePor || toFlag !== eTo || pdFlag !== ePd || resumePc !== ePc ||
        (borKnown && borFlag !== eBor)) begin
      nBad++;
      $display("FAIL %s: got por=%b bor=%b to=%b pd=%b pc=%h, expected por=%b bor=%b(known=%b) to=%b pd=%b pc=%h",
               curReq, porFlag, borFlag, toFlag, pdFlag, resumePc,
               ePor, eBor, borKnown, eTo, ePd, ePc);
    end
  endtask

  // drive at a falling edge, update the model, compare at the next falling edge
  task automatic step(input logic [7:0] e, input logic g, input logic we,
                      input logic sp, input logic sb, input logic [PC_W-1:0] pc);
    logic porClr, borClr;
    ev = e; gie = g; swWrEn = we; swPor = sp; swBor = sb; pcIn = pc;
    porClr = 1'b0; borClr = 1'b0;
    curReq = ($countones(e) > 1) ? "R8" : "R9";
    if (e[0]) begin
      porClr = 1'b1; eTo = 1'b1; ePd = 1'b1; ePc = '0; borKnown = 1'b0;
      if (curReq != "R8") curReq = "R2";
    end else if (e[1]) begin
      borClr = 1'b1; eTo = 1'b1; ePd = 1'b1; ePc = '0;
      if (curReq != "R8") curReq = "R3";
    end else if (e[2]) begin
      eTo = 1'b1; ePd = 1'b0; ePc = '0;
      if (curReq != "R8") curReq = "R5";
    end else if (e[3]) begin
      ePc = '0;
      if (curReq != "R8") curReq = "R5";
    end else if (e[4]) begin
      eTo = 1'b0; ePd = 1'b1; ePc = '0;
      if (curReq != "R8") curReq = "R4";
    end else if (e[5]) begin
      eTo = 1'b0; ePd = 1'b0; ePc = pc + 1'b1;
      if (curReq != "R8") curReq = "R4";
    end else if (e[6]) begin
      eTo = 1'b1; ePd = 1'b0; ePc = g ? VEC : PC_W'(pc + 1'b1);
      if (curReq != "R8") curReq = "R6";
    end else if (e[7]) begin
      eTo = 1'b1; ePd = 1'b0;
      if (curReq != "R8") curReq = "R7";
    end
    if (porClr) ePor = 1'b0;
    else if (we) ePor = sp;
    if (borClr) begin eBor = 1'b0; borKnown = 1'b1; end
    else if (we) begin eBor = sb; borKnown = 1'b1; end
    @(negedge clk);
    compare();
  endtask

  logic done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    compare();
    rstN = 1'b1;
    @(negedge clk);
    compare();
    // all strobe combinations under several side-input patterns
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 256; c++) begin
        logic [PC_W-1:0] pc;
        pc = (rep == 3) ? {PC_W{1'b1}} : PC_W'(c * 37 + rep * 1001);
        step(8'(c), rep[0], c[0] ^ rep[1], c[2] ^ rep[1], c[5] ^ rep[0], pc);
      end
    end
    // single events after setting flags to 1, including clear-versus-set
    for (int k = 0; k < 64; k++) begin
      logic [7:0] e;
      e = 8'(1) << (k % 8);
      step(8'h00, 1'b0, 1'b1, 1'b1, 1'b1, '0);
      step(e, k[3], k[4], k[5], k[5], (k[3]) ? {PC_W{1'b1}} : PC_W'(k * 91));
      step(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, PC_W'(k));
    end
    ev = '0; swWrEn = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule